// File: doc/BRIEF.md
# Two-Level Virtual Address Translator

This block turns a 32-bit virtual address into a 34-bit physical address. It does so by reading page-table entries from memory across two levels. A caller pulses `start` with the address, the access kind, the effective privilege and the translation control word. The block then issues one entry read per level on a simple request/response memory port. It checks the leaf entry against the access kind and the privilege rules, and returns the physical address with read, write and execute permissions, or a fault.

When a permitted leaf still needs its accessed flag, or its dirty flag on a store, the block reads the entry again. If the entry is unchanged, the block writes the updated value. If another agent has altered it in the meantime, the walk starts over from the root. The block skips the memory walk in two cases: when translation is switched off in the control word, and when the caller runs at machine privilege. In both cases the address passes through with every permission granted.

Top module: `pagewalk32`

## Requirements
- R1: Each entry address is the current table page number times 4096, plus the index times 4. The index is va[31:22] at the root and va[21:12] at the second level. The root page number is ctl[21:0]. A leaf at the second level yields pa = {entry[31:10], va[11:0]}.
- R2: Entry bits are V=0, R=1, W=2, X=3, U=4, A=6, D=7, and the page number sits in [31:10]. These cases fault: V clear; W set with R clear (the write-only and write+execute combinations); an entry with R, W and X all clear found at the second level.
- R3: The privilege codes are 0 user, 1 supervisor and 3 machine. A U=1 page accessed at supervisor privilege faults unless sum_en is set. A fetch from a U=1 page at supervisor privilege always faults. A U=0 page accessed at user privilege faults.
- R4: The access codes are 0 fetch, 1 load and 2 store. A load needs R, or X when mxr_en is set. A store needs W. A fetch needs X. Otherwise the access faults.
- R5: A leaf found at the root whose entry[19:10] is nonzero faults as a misaligned superpage. Otherwise pa = {entry[31:20], va[21:0]}.
- R6: On success, perm_r = R | (X & mxr_en) and perm_x = X. perm_w = W & (store | D), where D is the value read by the walk. On a fault, all three permissions are 0.
- R7: A successful leaf with A clear, or a store hitting a leaf with D clear, causes the entry to be read again and then written with A set (and D set for a store). No write is made on a fault or when the flags are already set.
- R8: If the second read of the entry differs from the first, nothing is written and the walk restarts from the root.
- R9: When ctl[31] is 0, or privilege is machine, pa is the zero-extended va and all permissions are 1. No memory access is made, and done rises in the cycle after start.
- R10: start is accepted only while idle. done is a one-cycle pulse. Each mem_req lasts one cycle and is answered by exactly one mem_rvalid, at least one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a translation (idle only) |
| vaddr | input | 32 | Virtual address |
| acc | input | 2 | Access kind: 0 fetch, 1 load, 2 store |
| priv | input | 2 | Effective privilege: 0 user, 1 supervisor, 3 machine |
| ctl | input | 32 | Bit 31 enables translation, [21:0] root page number |
| sum_en | input | 1 | Permit supervisor data access to user pages |
| mxr_en | input | 1 | Let executable pages satisfy loads |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Page fault, valid with done |
| paddr | output | 34 | Physical address, valid with done |
| perm_r | output | 1 | Read permission |
| perm_w | output | 1 | Write permission |
| perm_x | output | 1 | Execute permission |
| mem_req | output | 1 | Memory request pulse |
| mem_addr | output | 34 | Entry byte address |
| mem_we | output | 1 | Request is a write |
| mem_wdata | output | 32 | Updated entry for a write |
| mem_rvalid | input | 1 | Response strobe |
| mem_rdata | input | 32 | Entry read data (ignored for writes) |

## Verification
The inline properties check the following on every cycle:
- done lasts one cycle, and each memory request lasts one cycle.
- Entry addresses are word aligned.
- Every write carries the accessed flag, plus the dirty flag when a store caused it.
- A fault reports no permissions.
- A successful store reports write permission, and a successful fetch reports execute permission.
- A pass-through result equals the input address.

Only the bench scenarios can show the rest. These include the full mapping of addresses through pointer and leaf entries, and the interplay of the user flag with sum_en, mxr_en and privilege. They also include the superpage merge and the misaligned case, whether an update write happens at all, and the restart when another agent alters an entry between the walk's read and the check read.

// File: rtl/pw_pkg.sv
package pw_pkg;

   typedef enum logic [1:0] {
      ACC_FETCH = 2'd0,
      ACC_LOAD  = 2'd1,
      ACC_STORE = 2'd2,
      ACC_RSVD  = 2'd3
   } acc_e;

   localparam logic [1:0] PRV_USER = 2'd0;
   localparam logic [1:0] PRV_MACH = 2'd3;

   localparam int unsigned BIT_V = 0;
   localparam int unsigned BIT_R = 1;
   localparam int unsigned BIT_W = 2;
   localparam int unsigned BIT_X = 3;
   localparam int unsigned BIT_U = 4;
   localparam int unsigned BIT_G = 5;
   localparam int unsigned BIT_A = 6;
   localparam int unsigned BIT_D = 7;
   localparam int unsigned PPN_LSB = 10;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_FETCH,
      ST_FWAIT,
      ST_CHK,
      ST_CWAIT,
      ST_WRITE,
      ST_WWAIT
   } walk_st_e;

endpackage

// File: rtl/pw_addr_gen.sv
module pw_addr_gen #(
   parameter int unsigned VA_W      = 32,
   parameter int unsigned PA_W      = 34,
   parameter int unsigned PG_SHIFT  = 12,
   parameter int unsigned IDX_W     = 10,
   parameter int unsigned LEVELS    = 2,
   parameter int unsigned PTE_BYTES = 4,
   parameter int unsigned PPN_W     = PA_W - PG_SHIFT,
   parameter int unsigned LVL_W     = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
   input  logic [VA_W-1:0]  va,
   input  logic [PPN_W-1:0] base_ppn,
   input  logic [LVL_W-1:0] level,
   input  logic [PPN_W-1:0] leaf_ppn,
   output logic [PA_W-1:0]  pte_addr,
   output logic [PPN_W-1:0] sp_mask,
   output logic [PA_W-1:0]  leaf_pa
);
   localparam int unsigned PTE_SH = $clog2(PTE_BYTES);
   localparam int unsigned VPN_W  = VA_W - PG_SHIFT;

   initial begin : elab_chk
      assert (PG_SHIFT + LEVELS * IDX_W == VA_W)
         else $error("levels and index width do not cover the virtual address");
      assert (VPN_W <= PPN_W)
         else $error("virtual page number wider than physical page number");
      assert ((1 << PTE_SH) == PTE_BYTES)
         else $error("entry size must be a power of two");
   end

   logic [IDX_W-1:0] idx_arr  [LEVELS];
   logic [PPN_W-1:0] mask_arr [LEVELS];

   for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
      localparam int unsigned SH = (LEVELS - 1 - l) * IDX_W;
      assign idx_arr[l]  = va[PG_SHIFT + SH +: IDX_W];
      assign mask_arr[l] = {PPN_W{1'b1}} >> (PPN_W - SH);
   end

   logic [PPN_W-1:0] vpn_ext;
   logic [PPN_W-1:0] ppn_merged;

   assign vpn_ext    = PPN_W'(va[VA_W-1:PG_SHIFT]);
   assign sp_mask    = mask_arr[level];
   assign ppn_merged = (leaf_ppn & ~sp_mask) | (vpn_ext & sp_mask);
   assign leaf_pa    = {ppn_merged, va[PG_SHIFT-1:0]};
   assign pte_addr   = {base_ppn, {PG_SHIFT{1'b0}}} + (PA_W'(idx_arr[level]) << PTE_SH);

endmodule

// File: rtl/pw_pte_eval.sv
module pw_pte_eval
   import pw_pkg::*;
#(
   parameter int unsigned PTE_W = 32,
   parameter int unsigned PPN_W = 22
) (
   input  logic [PTE_W-1:0] pte,
   input  logic             last_lvl,
   input  logic [PPN_W-1:0] sp_mask,
   input  acc_e             acc,
   input  logic             user_mode,
   input  logic             sum_en,
   input  logic             mxr_en,
   output logic             is_ptr,
   output logic             bad,
   output logic             need_upd,
   output logic [PTE_W-1:0] new_pte,
   output logic             pr,
   output logic             pw,
   output logic             px
);
   initial begin : elab_chk
      assert (PTE_W - PPN_W == PPN_LSB)
         else $error("page number field does not start at its fixed bit");
   end

   logic v, r, w, x, u, a, d, leaf, fetch, store;
   logic u_fail, acc_fail, misalign;
   logic [PPN_W-1:0] ppn;
   logic unused_pte;

   assign v     = pte[BIT_V];
   assign r     = pte[BIT_R];
   assign w     = pte[BIT_W];
   assign x     = pte[BIT_X];
   assign u     = pte[BIT_U];
   assign a     = pte[BIT_A];
   assign d     = pte[BIT_D];
   assign ppn   = pte[PPN_LSB +: PPN_W];
   assign unused_pte = ^{pte[BIT_G], pte[PPN_LSB-1:BIT_D+1]};
   assign leaf  = r | w | x;
   assign fetch = (acc == ACC_FETCH);
   assign store = (acc == ACC_STORE);

   always_comb begin
      unique case (acc)
         ACC_FETCH: acc_fail = !x;
         ACC_LOAD:  acc_fail = !(r | (x & mxr_en));
         ACC_STORE: acc_fail = !w;
         default:   acc_fail = 1'b1;
      endcase
   end

   assign u_fail   = u ? (!user_mode && (!sum_en || fetch)) : user_mode;
   assign misalign = |(ppn & sp_mask);

   assign is_ptr   = v & !leaf & !last_lvl;
   assign bad      = !v | (w & !r) | (!leaf & last_lvl) |
                     (leaf & (u_fail | misalign | acc_fail));
   assign need_upd = !a | (store & !d);
   assign new_pte  = pte | (PTE_W'(1) << BIT_A) | (store ? (PTE_W'(1) << BIT_D) : '0);
   assign pr       = r | (x & mxr_en);
   assign pw       = w & (store | d);
   assign px       = x;

endmodule

// File: rtl/pagewalk32.sv
module pagewalk32
   import pw_pkg::*;
#(
   parameter int unsigned VA_W      = 32,
   parameter int unsigned PA_W      = 34,
   parameter int unsigned PG_SHIFT  = 12,
   parameter int unsigned IDX_W     = 10,
   parameter int unsigned LEVELS    = 2,
   parameter int unsigned PTE_W     = 32,
   parameter int unsigned PTE_BYTES = 4,
   parameter int unsigned CTL_W     = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [VA_W-1:0]  vaddr,
   input  logic [1:0]       acc,
   input  logic [1:0]       priv,
   input  logic [CTL_W-1:0] ctl,
   input  logic             sum_en,
   input  logic             mxr_en,
   output logic             done,
   output logic             fault,
   output logic [PA_W-1:0]  paddr,
   output logic             perm_r,
   output logic             perm_w,
   output logic             perm_x,
   output logic             mem_req,
   output logic [PA_W-1:0]  mem_addr,
   output logic             mem_we,
   output logic [PTE_W-1:0] mem_wdata,
   input  logic             mem_rvalid,
   input  logic [PTE_W-1:0] mem_rdata
);
   localparam int unsigned PPN_W  = PA_W - PG_SHIFT;
   localparam int unsigned LVL_W  = (LEVELS > 1) ? $clog2(LEVELS) : 1;
   localparam int unsigned PTE_SH = $clog2(PTE_BYTES);
   localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(LEVELS - 1);

   initial begin : elab_chk
      assert (CTL_W > PPN_W + 1)
         else $error("control word too narrow for root page number and mode bit");
      assert (PTE_W == 8 * PTE_BYTES)
         else $error("entry width and entry size disagree");
      assert (LEVELS >= 2)
         else $error("walker needs at least two levels");
   end

   walk_st_e         st;
   logic [LVL_W-1:0] lvl;
   logic [PPN_W-1:0] base_ppn, root_q;
   logic [VA_W-1:0]  va_q;
   acc_e             acc_q;
   logic [1:0]       prv_q;
   logic             sum_q, mxr_q, pass_q;
   logic [PTE_W-1:0] orig_q, upd_q;

   logic             done_q, fault_q, r_q, w_q, x_q;
   logic [PA_W-1:0]  pa_q;

   logic [PA_W-1:0]  pte_addr, leaf_pa;
   logic [PPN_W-1:0] sp_mask;
   logic             is_ptr, bad, need_upd, e_r, e_w, e_x;
   logic [PTE_W-1:0] new_pte;
   logic             unused_ctl;

   assign unused_ctl = ^ctl[CTL_W-2:PPN_W];

   pw_addr_gen #(
      .VA_W(VA_W), .PA_W(PA_W), .PG_SHIFT(PG_SHIFT), .IDX_W(IDX_W),
      .LEVELS(LEVELS), .PTE_BYTES(PTE_BYTES), .PPN_W(PPN_W), .LVL_W(LVL_W)
   ) i_addr (
      .va       (va_q),
      .base_ppn (base_ppn),
      .level    (lvl),
      .leaf_ppn (mem_rdata[PPN_LSB +: PPN_W]),
      .pte_addr (pte_addr),
      .sp_mask  (sp_mask),
      .leaf_pa  (leaf_pa)
   );

   pw_pte_eval #(
      .PTE_W(PTE_W), .PPN_W(PPN_W)
   ) i_eval (
      .pte       (mem_rdata),
      .last_lvl  (lvl == LAST_LVL),
      .sp_mask   (sp_mask),
      .acc       (acc_q),
      .user_mode (prv_q == PRV_USER),
      .sum_en    (sum_q),
      .mxr_en    (mxr_q),
      .is_ptr    (is_ptr),
      .bad       (bad),
      .need_upd  (need_upd),
      .new_pte   (new_pte),
      .pr        (e_r),
      .pw        (e_w),
      .px        (e_x)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         lvl      <= '0;
         base_ppn <= '0;
         root_q   <= '0;
         va_q     <= '0;
         acc_q    <= ACC_FETCH;
         prv_q    <= '0;
         sum_q    <= 1'b0;
         mxr_q    <= 1'b0;
         pass_q   <= 1'b0;
         orig_q   <= '0;
         upd_q    <= '0;
         done_q   <= 1'b0;
         fault_q  <= 1'b0;
         pa_q     <= '0;
         r_q      <= 1'b0;
         w_q      <= 1'b0;
         x_q      <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (st)
            ST_IDLE: begin
               if (start) begin
                  va_q     <= vaddr;
                  acc_q    <= acc_e'(acc);
                  prv_q    <= priv;
                  sum_q    <= sum_en;
                  mxr_q    <= mxr_en;
                  root_q   <= ctl[PPN_W-1:0];
                  base_ppn <= ctl[PPN_W-1:0];
                  lvl      <= '0;
                  if (!ctl[CTL_W-1] || priv == PRV_MACH) begin
                     pass_q  <= 1'b1;
                     done_q  <= 1'b1;
                     fault_q <= 1'b0;
                     pa_q    <= PA_W'(vaddr);
                     r_q     <= 1'b1;
                     w_q     <= 1'b1;
                     x_q     <= 1'b1;
                  end else begin
                     pass_q <= 1'b0;
                     st     <= ST_FETCH;
                  end
               end
            end
            ST_FETCH: st <= ST_FWAIT;
            ST_FWAIT: begin
               if (mem_rvalid) begin
                  if (bad) begin
                     done_q  <= 1'b1;
                     fault_q <= 1'b1;
                     pa_q    <= '0;
                     r_q     <= 1'b0;
                     w_q     <= 1'b0;
                     x_q     <= 1'b0;
                     st      <= ST_IDLE;
                  end else if (is_ptr) begin
                     base_ppn <= mem_rdata[PPN_LSB +: PPN_W];
                     lvl      <= lvl + 1'b1;
                     st       <= ST_FETCH;
                  end else begin
                     fault_q <= 1'b0;
                     pa_q    <= leaf_pa;
                     r_q     <= e_r;
                     w_q     <= e_w;
                     x_q     <= e_x;
                     if (need_upd) begin
                        orig_q <= mem_rdata;
                        upd_q  <= new_pte;
                        st     <= ST_CHK;
                     end else begin
                        done_q <= 1'b1;
                        st     <= ST_IDLE;
                     end
                  end
               end
            end
            ST_CHK: st <= ST_CWAIT;
            ST_CWAIT: begin
               if (mem_rvalid) begin
                  if (mem_rdata != orig_q) begin
                     lvl      <= '0;
                     base_ppn <= root_q;
                     st       <= ST_FETCH;
                  end else begin
                     st <= ST_WRITE;
                  end
               end
            end
            ST_WRITE: st <= ST_WWAIT;
            ST_WWAIT: begin
               if (mem_rvalid) begin
                  done_q <= 1'b1;
                  st     <= ST_IDLE;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign mem_req   = (st == ST_FETCH) || (st == ST_CHK) || (st == ST_WRITE);
   assign mem_we    = (st == ST_WRITE);
   assign mem_addr  = pte_addr;
   assign mem_wdata = upd_q;

   assign done   = done_q;
   assign fault  = fault_q;
   assign paddr  = pa_q;
   assign perm_r = r_q;
   assign perm_w = w_q;
   assign perm_x = x_q;

   p_addr_aligned_r1: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (mem_addr[PTE_SH-1:0] == '0));

   p_fault_noperm_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (done && fault) |-> (!perm_r && !perm_w && !perm_x));

   p_fetch_exec_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !fault && acc_q == ACC_FETCH) |-> perm_x);

   p_store_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !fault && acc_q == ACC_STORE) |-> perm_w);

   p_wr_accessed_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> mem_wdata[BIT_A]);

   p_wr_dirty_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we && acc_q == ACC_STORE) |-> mem_wdata[BIT_D]);

   p_pass_through_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (done && pass_q) |-> (paddr == PA_W'(va_q) && perm_r && perm_w && perm_x && !fault));

   p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_req_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |=> !mem_req);

endmodule

// File: tb/test_pagewalk32.sv
`timescale 1ns/1ps
module test_pagewalk32;

   logic        clk = 1'b0;
   logic        rst_n, start, sum_en, mxr_en, mem_rvalid;
   logic [31:0] vaddr, ctl, mem_rdata, mem_wdata;
   logic [1:0]  acc, priv;
   logic        done, fault, perm_r, perm_w, perm_x, mem_req, mem_we;
   logic [33:0] paddr, mem_addr;

   always #4 clk = ~clk;

   pagewalk32 i_pagewalk32 (
      .clk(clk), .rst_n(rst_n), .start(start), .vaddr(vaddr), .acc(acc),
      .priv(priv), .ctl(ctl), .sum_en(sum_en), .mxr_en(mxr_en),
      .done(done), .fault(fault), .paddr(paddr), .perm_r(perm_r),
      .perm_w(perm_w), .perm_x(perm_x), .mem_req(mem_req),
      .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
      .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
   );

   // memory model: 16 KiB, two-cycle response
   logic [31:0] mem [4096];
   logic        pend = 1'b0;
   logic [33:0] p_addr;
   logic        p_we;
   logic [31:0] p_wd;
   int          dly = 0;
   int          nrd = 0, nwr = 0;
   logic        tamper_on = 1'b0;
   logic        tamper_used = 1'b0;
   logic [33:0] tamper_addr = '0;
   logic [31:0] tamper_val = '0;

   initial begin
      mem_rvalid = 1'b0;
      mem_rdata  = '0;
   end

   always @(posedge clk) begin
      mem_rvalid <= 1'b0;
      if (mem_req) begin
         pend   <= 1'b1;
         p_addr <= mem_addr;
         p_we   <= mem_we;
         p_wd   <= mem_wdata;
         dly    <= 1;
         if (mem_we) nwr <= nwr + 1;
         else        nrd <= nrd + 1;
      end else if (pend) begin
         if (dly != 0) dly <= dly - 1;
         else begin
            pend       <= 1'b0;
            mem_rvalid <= 1'b1;
            mem_rdata  <= mem[p_addr[13:2]];
            if (p_we) mem[p_addr[13:2]] <= p_wd;
            else if (tamper_on && !tamper_used && p_addr == tamper_addr) begin
               mem[p_addr[13:2]] <= tamper_val;
               tamper_used       <= 1'b1;
            end
         end
      end
   end

   function automatic logic [31:0] mkpte(input logic [21:0] ppn, input logic [7:0] fl);
      return {ppn, 2'b00, fl};
   endfunction

   int nchk = 0, nfail = 0;

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   logic        r_fault;
   logic [33:0] r_pa;
   logic [2:0]  r_rwx;
   int          r_rd, r_wr;

   task automatic run(input logic [31:0] va, input logic [1:0] a, input logic [1:0] p,
                      input logic s, input logic m, input logic paged);
      int rd0, wr0;
      bit seen;
      rd0 = nrd; wr0 = nwr;
      @(negedge clk);
      vaddr = va; acc = a; priv = p; sum_en = s; mxr_en = m;
      ctl = paged ? {1'b1, 9'd0, 22'd1} : {10'd0, 22'd1};
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      seen = 1'b0;
      for (int i = 0; i < 200 && !seen; i++) begin
         if (done) seen = 1'b1;
         else @(negedge clk);
      end
      chk(seen, "R10 done seen", 64'(seen), 64'd1);
      r_fault = fault; r_pa = paddr; r_rwx = {perm_r, perm_w, perm_x};
      r_rd = nrd - rd0; r_wr = nwr - wr0;
      @(negedge clk);
      chk(!done, "R10 done one cycle", 64'(done), 64'd0);
   endtask

   typedef struct packed {
      logic [31:0] va;
      logic [1:0]  acc;
      logic [1:0]  prv;
      logic        sum;
      logic        mxr;
      logic        paged;
      logic        flt;
      logic [33:0] pa;
      logic [2:0]  rwx;
   } vec_t;

   localparam int NV = 23;
   // acc 0 fetch 1 load 2 store; prv 0 U 1 S 3 M; rwx = {r,w,x}
   localparam vec_t VECS [NV] = '{
      '{32'h00000123, 2'd1, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 34'h012345123, 3'b111}, // R1 R3 user ok
      '{32'h00000123, 2'd1, 2'd1, 1'b0, 1'b0, 1'b1, 1'b1, 34'h0,         3'b000}, // R3 no sum
      '{32'h00000123, 2'd1, 2'd1, 1'b1, 1'b0, 1'b1, 1'b0, 34'h012345123, 3'b111}, // R3 sum
      '{32'h00000123, 2'd0, 2'd1, 1'b1, 1'b0, 1'b1, 1'b1, 34'h0,         3'b000}, // R3 fetch user
      '{32'h00001004, 2'd1, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 34'h0,         3'b000}, // R3 sup page
      '{32'h00001004, 2'd1, 2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 34'h000777004, 3'b100}, // R1 load
      '{32'h00001004, 2'd2, 2'd1, 1'b0, 1'b0, 1'b1, 1'b1, 34'h0,         3'b000}, // R4 store no W
      '{32'h00002010, 2'd1, 2'd1, 1'b0, 1'b0, 1'b1, 1'b1, 34'h0,         3'b000}, // R4 X no mxr
      '{32'h00002010, 2'd1, 2'd1, 1'b0, 1'b1, 1'b1, 1'b0, 34'h000888010, 3'b101}, // R4 R6 mxr
      '{32'h00002010, 2'd0, 2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 34'h000888010, 3'b001}, // R4 fetch
      '{32'h00003000, 2'd1, 2'd1, 1'b0, 1'b0, 1'b1, 1'b1, 34'h0,         3'b000}, // R2 W only
      '{32'h00004000, 2'd1, 2'd1, 1'b0, 1'b0, 1'b1, 1'b1, 34'h0,         3'b000}, // R2 W+X
      '{32'h00005008, 2'd1, 2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 34'h000999008, 3'b100}, // R6 D clear
      '{32'h00005008, 2'd2, 2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 34'h000999008, 3'b110}, // R7 store sets D
      '{32'h00005008, 2'd1, 2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 34'h000999008, 3'b110}, // R6 D now set
      '{32'h00456789, 2'd1, 2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 34'h000C56789, 3'b111}, // R5 superpage
      '{32'h00800000, 2'd1, 2'd1, 1'b0, 1'b0, 1'b1, 1'b1, 34'h0,         3'b000}, // R5 misaligned
      '{32'h00C00000, 2'd1, 2'd1, 1'b0, 1'b0, 1'b1, 1'b1, 34'h0,         3'b000}, // R2 invalid
      '{32'h01000000, 2'd1, 2'd1, 1'b0, 1'b0, 1'b1, 1'b1, 34'h0,         3'b000}, // R2 pointer at last
      '{32'h00003000, 2'd1, 2'd3, 1'b0, 1'b0, 1'b1, 1'b0, 34'h000003000, 3'b111}, // R9 machine
      '{32'hFFFFF123, 2'd2, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 34'h0FFFFF123, 3'b111}, // R9 bare
      '{32'h00008000, 2'd0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 34'h0,         3'b000}, // R4 user fetch no X
      '{32'h00008000, 2'd1, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 34'h000111000, 3'b100}  // R3 user load
   };

   initial begin : watchdog
      #(8 * 150000);
      nfail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end

   initial begin
      rst_n = 1'b0; start = 1'b0; vaddr = '0; acc = '0; priv = '0;
      ctl = '0; sum_en = 1'b0; mxr_en = 1'b0;
      for (int i = 0; i < 4096; i++) mem[i] <= 32'h0;
      #1;
      // root table at page 1
      mem[12'h400 + 0] <= mkpte(22'h2, 8'h01);
      mem[12'h400 + 1] <= mkpte(22'hC00, 8'hCF);
      mem[12'h400 + 2] <= mkpte(22'h401, 8'h43);
      mem[12'h400 + 4] <= mkpte(22'h3, 8'h01);
      // leaf table at page 2
      mem[12'h800 + 0] <= mkpte(22'h12345, 8'hDF);
      mem[12'h800 + 1] <= mkpte(22'h777, 8'h43);
      mem[12'h800 + 2] <= mkpte(22'h888, 8'h49);
      mem[12'h800 + 3] <= mkpte(22'h100, 8'h45);
      mem[12'h800 + 4] <= mkpte(22'h100, 8'h4D);
      mem[12'h800 + 5] <= mkpte(22'h999, 8'h47);
      mem[12'h800 + 6] <= mkpte(22'hAAA, 8'h03);
      mem[12'h800 + 7] <= mkpte(22'hBBB, 8'h07);
      mem[12'h800 + 8] <= mkpte(22'h111, 8'h53);
      // table at page 3 holds a pointer at the last level
      mem[12'hC00 + 0] <= mkpte(22'h2, 8'h01);

      repeat (3) @(negedge clk);
      chk(!done, "R10 reset done low", 64'(done), 64'd0);
      chk(!mem_req, "R10 reset no request", 64'(mem_req), 64'd0);
      rst_n = 1'b1;

      for (int k = 0; k < NV; k++) begin
         run(VECS[k].va, VECS[k].acc, VECS[k].prv, VECS[k].sum, VECS[k].mxr, VECS[k].paged);
         chk(r_fault == VECS[k].flt, $sformatf("R2/R3/R4 vector %0d fault", k),
             64'(r_fault), 64'(VECS[k].flt));
         if (!VECS[k].flt) begin
            chk(r_pa == VECS[k].pa, $sformatf("R1/R5 vector %0d paddr", k),
                64'(r_pa), 64'(VECS[k].pa));
            chk(r_rwx == VECS[k].rwx, $sformatf("R6 vector %0d perms", k),
                64'(r_rwx), 64'(VECS[k].rwx));
         end else begin
            chk(r_rwx == 3'b000, $sformatf("R6 vector %0d fault perms", k), 64'(r_rwx), 64'd0);
         end
         if (!VECS[k].paged || VECS[k].prv == 2'd3)
            chk(r_rd == 0 && r_wr == 0, "R9 no memory access", 64'(r_rd + r_wr), 64'd0);
      end

      // R7: load hits leaf with A clear -> check read then write with A only
      run(32'h00006000, 2'd1, 2'd1, 1'b0, 1'b0, 1'b1);
      chk(!r_fault && r_pa == 34'h000AAA000, "R7 A update result", 64'(r_pa), 64'h0AAA000);
      chk(r_rd == 3 && r_wr == 1, "R7 accesses", 64'({r_rd[15:0], r_wr[15:0]}), 64'h00030001);
      chk(mem[12'h806] == mkpte(22'hAAA, 8'h43), "R7 written entry",
          64'(mem[12'h806]), 64'(mkpte(22'hAAA, 8'h43)));

      // R7: flags already set -> no write
      run(32'h00006000, 2'd1, 2'd1, 1'b0, 1'b0, 1'b1);
      chk(r_rd == 2 && r_wr == 0, "R7 no write when set", 64'({r_rd[15:0], r_wr[15:0]}), 64'h00020000);

      // R7: faulting store makes no write
      run(32'h00001004, 2'd2, 2'd1, 1'b0, 1'b0, 1'b1);
      chk(r_fault && r_wr == 0, "R7 no write on fault", 64'(r_wr), 64'd0);

      // R8: entry changes between walk read and check read -> restart
      tamper_addr = 34'h00000201C;
      tamper_val  = mkpte(22'hCCC, 8'hC7);
      tamper_on   = 1'b1;
      run(32'h00007000, 2'd2, 2'd1, 1'b0, 1'b0, 1'b1);
      chk(!r_fault && r_pa == 34'h000CCC000, "R8 restart result", 64'(r_pa), 64'h0CCC000);
      chk(r_rwx == 3'b110, "R8 restart perms", 64'(r_rwx), 64'h6);
      chk(r_rd == 5 && r_wr == 0, "R8 restart accesses", 64'({r_rd[15:0], r_wr[15:0]}), 64'h00050000);
      chk(mem[12'h807] == mkpte(22'hCCC, 8'hC7), "R8 entry not overwritten",
          64'(mem[12'h807]), 64'(mkpte(22'hCCC, 8'hC7)));

      // R10: start while busy is ignored; one result only
      @(negedge clk);
      vaddr = 32'h00001004; acc = 2'd1; priv = 2'd1; sum_en = 1'b0; mxr_en = 1'b0;
      ctl = {1'b1, 9'd0, 22'd1};
      start = 1'b1;
      @(negedge clk);
      vaddr = 32'h00000123; acc = 2'd2;
      @(negedge clk);
      start = 1'b0;
      begin
         int ndone = 0;
         logic [33:0] pa_seen = '0;
         for (int i = 0; i < 40; i++) begin
            if (done) begin ndone++; pa_seen = paddr; end
            @(negedge clk);
         end
         chk(ndone == 1, "R10 busy start ignored count", 64'(ndone), 64'd1);
         chk(pa_seen == 34'h000777004, "R10 busy start ignored paddr", 64'(pa_seen), 64'h777004);
      end

      $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end

endmodule